// File: doc/BRIEF.md
# Oversampled Clock Recovery Loop

This block rebuilds bit timing from a serial line. A local oversampling tick comes from one of two selectable sources: an internal rate generator or an external clock pin. On each tick a 5-bit phase counter advances through one bit cell. The cell is 32 ticks long in NRZI/NRZ mode and 16 ticks long in FM mode. A transition detector compares each line sample with the sample from the previous tick. A count modifier then corrects the counter by one tick when a transition arrives ahead of or behind the expected cell boundary.

Two decoders watch the counter. A transmit strobe marks each cell boundary and a receive strobe marks the middle of each cell, so a receiver can sample data at mid-cell. In FM mode only transitions near the cell boundary steer the loop, and transitions near mid-cell are ignored. Manchester data can therefore be locked on its centre transitions and read as plain NRZ at the receive strobe. A sticky flag reports FM streams that have lost their transitions.

All logic runs on one system clock. Source ticks are single-cycle enables, and the commands arrive as a 3-bit code qualified by a valid bit.

Top module: `dpll_clock_recovery`

## Requirements
- R1: After reset the block is disabled, in NRZI mode, set to the rate-generator source, searching, and every output is low.
- R2: Commands are taken only when cmdValid is high. Code 3'b100 enables the block on brgTick and code 3'b101 enables it on pinTick. Ticks from the unselected source have no effect. Code 3'b011 disables the block, which freezes it without strobes. Code 3'b000 changes nothing.
- R3: Code 3'b110 selects NRZI mode (a 32-tick cell) and code 3'b111 selects FM mode (a 16-tick cell). Either mode command returns the block to searching, with locked low.
- R4: While searching, the first tick whose line sample differs from the previous tick's sample sets the phase to zero, pulses txClk and raises locked.
- R5: While locked with no corrections, txClk pulses once every cell length in ticks. rxClk pulses half a cell after each boundary. The two never pulse together.
- R6: An early transition (phase between half-cell and cell length minus 2) advances the phase by two instead of one, so the current cell is one tick shorter.
- R7: A late transition (phase below half-cell) holds the phase, so the current cell is one tick longer. A transition at phase cell length minus 1 leaves the cell length unchanged.
- R8: In FM mode only transitions at phase 12 or above, or below 4, correct the loop. Transitions at phases 4 to 11 are ignored.
- R9: In FM mode, two consecutive locked cells without any transition set missingClk at the second boundary. The flag stays set until code 3'b010 and never sets in NRZI mode.
- R10: Code 3'b001 returns the block to searching. locked drops and no strobe appears until the next transition.
- R11: Each strobe is registered on the tick's clock edge, visible in the clock cycle after that edge, and lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Qualifies cmdCode for one cycle |
| cmdCode | input | 3 | Command code |
| brgTick | input | 1 | Oversampling tick from the internal rate generator |
| pinTick | input | 1 | Oversampling tick from the external clock pin |
| rxData | input | 1 | Received serial line |
| txClk | output | 1 | Cell-boundary strobe |
| rxClk | output | 1 | Mid-cell strobe |
| locked | output | 1 | High while tracking the line |
| missingClk | output | 1 | Sticky FM lost-transition flag |

## Verification
A wrong phase count or a misplaced correction shows up as a cell period off by one tick. It also moves the mid-cell strobe, and both are visible within one cell of the transition that caused it. The bench therefore places single transitions at chosen phases and measures the distance to the next strobes. A wrong mode, source or search state shows up at once: locked stays low, or a strobe appears or goes missing on the next tick. A broken lost-transition counter shows up exactly at the second empty boundary.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  // Command codes; the enable/source codes are the fixed encodings
  typedef enum logic [2:0] {
    CMD_NOP     = 3'b000,
    CMD_SEARCH  = 3'b001,
    CMD_CLRMISS = 3'b010,
    CMD_OFF     = 3'b011,
    CMD_SRC_BRG = 3'b100,
    CMD_SRC_PIN = 3'b101,
    CMD_NRZI    = 3'b110,
    CMD_FM      = 3'b111
  } dpllCmdE;

  // Control -> datapath strobes and levels
  typedef struct packed {
    logic tick;
    logic fmMode;
    logic tracking;
  } dpCtlT;

  // Datapath -> control events
  typedef struct packed {
    logic edgeNow;
    logic lockEvt;
    logic boundary;
  } dpStatT;

endpackage

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int NRZI_CELL = 32,
  parameter int FM_CELL   = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtlT  ctl,
  input  logic   rxData,
  output dpStatT stat,
  output logic   txStrobe,
  output logic   rxStrobe
);

  localparam int LEN_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt, nextCnt;
  logic [LEN_W-1:0] cellLen, halfLen, qtrLen, cntExt, incr, sumExt, nextExt;
  logic             prevData;
  logic             edgeNow, inWindow, earlyEdge, lateEdge;
  logic             lockEvt, boundary, midCell;

  // Edge detector: compare the current sample with the previous tick's
  always_comb begin
    edgeNow = ctl.tick && (rxData != prevData);
  end

  // Count modifier
  always_comb begin
    cellLen  = ctl.fmMode ? LEN_W'(FM_CELL) : LEN_W'(NRZI_CELL);
    halfLen  = cellLen >> 1;
    qtrLen   = cellLen >> 2;
    cntExt   = {1'b0, cnt};
    // FM: only edges near the boundary steer the loop
    inWindow = !ctl.fmMode || (cntExt >= cellLen - qtrLen) || (cntExt < qtrLen);
    earlyEdge = edgeNow && ctl.tracking && inWindow &&
                (cntExt >= halfLen) && (cntExt <= cellLen - LEN_W'(2));
    lateEdge  = edgeNow && ctl.tracking && inWindow && (cntExt < halfLen);
    if (earlyEdge)     incr = LEN_W'(2);
    else if (lateEdge) incr = '0;
    else               incr = LEN_W'(1);
    sumExt  = cntExt + incr;
    nextExt = (sumExt >= cellLen) ? sumExt - cellLen : sumExt;
    nextCnt = nextExt[CNT_W-1:0];
  end

  // Decoders
  always_comb begin
    lockEvt  = edgeNow && !ctl.tracking;
    boundary = ctl.tick && ctl.tracking && (nextCnt == '0) && (cnt != '0);
    midCell  = ctl.tick && ctl.tracking && (nextExt == halfLen) && (cntExt != halfLen);
    stat.edgeNow  = edgeNow;
    stat.lockEvt  = lockEvt;
    stat.boundary = boundary;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      prevData <= 1'b0;
      txStrobe <= 1'b0;
      rxStrobe <= 1'b0;
    end else begin
      txStrobe <= lockEvt || boundary;
      rxStrobe <= midCell;
      if (ctl.tick) prevData <= rxData;
      if (lockEvt) cnt <= '0;
      else if (ctl.tick && ctl.tracking) cnt <= nextCnt;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tracking |-> (cntExt < cellLen)); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txStrobe && rxStrobe)); // R5

  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (txStrobe || rxStrobe) |-> $past(ctl.tick)); // R11

  AST_LOCK_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    lockEvt |=> (cnt == '0)); // R4

endmodule

// File: rtl/dpll_ctrl.sv
module dpll_ctrl
  import dpll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       brgTick,
  input  logic       pinTick,
  input  dpStatT     stat,
  output dpCtlT      ctl,
  output logic       locked,
  output logic       missingClk
);

  logic enabled, srcPin, fmMode, tracking;
  logic missOne, edgeSeen, missFlag;

  always_comb begin
    ctl.tick     = enabled && (srcPin ? pinTick : brgTick);
    ctl.fmMode   = fmMode;
    ctl.tracking = tracking;
    locked       = tracking;
    missingClk   = missFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled  <= 1'b0;
      srcPin   <= 1'b0;
      fmMode   <= 1'b0;
      tracking <= 1'b0;
      missOne  <= 1'b0;
      edgeSeen <= 1'b0;
      missFlag <= 1'b0;
    end else begin
      // Loop events
      if (stat.lockEvt) begin
        tracking <= 1'b1;
        missOne  <= 1'b0;
        edgeSeen <= 1'b0;
      end else if (stat.boundary) begin
        edgeSeen <= 1'b0;
        if (edgeSeen || stat.edgeNow) missOne <= 1'b0;
        else if (missOne) begin
          if (fmMode) missFlag <= 1'b1;
        end else missOne <= 1'b1;
      end else if (stat.edgeNow && tracking) begin
        edgeSeen <= 1'b1;
      end
      // Commands take precedence
      if (cmdValid) begin
        case (cmdCode)
          CMD_SEARCH: begin
            tracking <= 1'b0;
            missOne  <= 1'b0;
            edgeSeen <= 1'b0;
          end
          CMD_CLRMISS: missFlag <= 1'b0;
          CMD_OFF:     enabled  <= 1'b0;
          CMD_SRC_BRG: begin
            enabled <= 1'b1;
            srcPin  <= 1'b0;
          end
          CMD_SRC_PIN: begin
            enabled <= 1'b1;
            srcPin  <= 1'b1;
          end
          CMD_NRZI: begin
            fmMode   <= 1'b0;
            tracking <= 1'b0;
            missOne  <= 1'b0;
            edgeSeen <= 1'b0;
          end
          CMD_FM: begin
            fmMode   <= 1'b1;
            tracking <= 1'b0;
            missOne  <= 1'b0;
            edgeSeen <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (missFlag && !(cmdValid && cmdCode == CMD_CLRMISS)) |=> missFlag); // R9

  AST_MISS_FM_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(missFlag) |-> $past(fmMode)); // R9

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !cmdValid) |=> $stable(tracking)); // R2

  AST_LOCK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!tracking && !stat.lockEvt) |=> !tracking); // R10

endmodule

// File: rtl/dpll_clock_recovery.sv
module dpll_clock_recovery
  import dpll_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int NRZI_CELL = 32,
  parameter int FM_CELL   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       brgTick,
  input  logic       pinTick,
  input  logic       rxData,
  output logic       txClk,
  output logic       rxClk,
  output logic       locked,
  output logic       missingClk
);

  dpCtlT  ctlBus;
  dpStatT statBus;

  dpll_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .brgTick   (brgTick),
    .pinTick   (pinTick),
    .stat      (statBus),
    .ctl       (ctlBus),
    .locked    (locked),
    .missingClk(missingClk)
  );

  dpll_datapath #(
    .CNT_W    (CNT_W),
    .NRZI_CELL(NRZI_CELL),
    .FM_CELL  (FM_CELL)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctlBus),
    .rxData  (rxData),
    .stat    (statBus),
    .txStrobe(txClk),
    .rxStrobe(rxClk)
  );

endmodule

// File: tb/test_dpll_clock_recovery.sv
module test_dpll_clock_recovery;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {fmMode, edgeTick (0 = none), expected tx tick, expected rx tick, req}
  localparam int VEC [NV][5] = '{
    '{0, 0, 32, 16, 5},
    '{0, 32, 32, 16, 7},
    '{0, 31, 31, 16, 6},
    '{0, 19, 31, 16, 6},
    '{0, 4, 33, 17, 7},
    '{0, 1, 33, 17, 7},
    '{1, 0, 16, 8, 5},
    '{1, 9, 16, 8, 8},
    '{1, 15, 15, 8, 6},
    '{1, 2, 17, 9, 7},
    '{1, 7, 16, 8, 8}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'b000;
  logic       brgTick = 1'b0;
  logic       pinTick = 1'b0;
  logic       rxData = 1'b0;
  logic       txClk, rxClk, locked, missingClk;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 0;
  logic dataLvl = 1'b0;

  dpll_clock_recovery i_dpll_clock_recovery (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .brgTick(brgTick), .pinTick(pinTick), .rxData(rxData),
    .txClk(txClk), .rxClk(rxClk), .locked(locked), .missingClk(missingClk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string reqName(input int n);
    case (n)
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [2:0] c);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = c;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = 3'b000;
  endtask

  task automatic tickOnce(input bit usePin, output logic txS, output logic rxS);
    @(negedge clk);
    rxData = dataLvl;
    if (usePin) pinTick = 1'b1;
    else        brgTick = 1'b1;
    @(negedge clk);
    brgTick = 1'b0;
    pinTick = 1'b0;
    txS = txClk;
    rxS = rxClk;
  endtask

  // Run n ticks without transitions, return strobe count
  task automatic runIdle(input int n, output int cnt);
    logic t, r;
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      tickOnce(0, t, r);
      cnt += int'(t) + int'(r);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic t, r;
    int   cnt, firstTx, firstRx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 txClk", txClk, 0);
    check("R1 rxClk", rxClk, 0);
    check("R1 locked", locked, 0);
    check("R1 missingClk", missingClk, 0);
    // R1/R2: disabled after reset, a transition does nothing
    dataLvl = 1'b1;
    tickOnce(0, t, r);
    check("R1 disabled tx", t, 0);
    check("R2 disabled lock", locked, 0);
    dataLvl = 1'b0;
    tickOnce(0, t, r);
    sendCmd(3'b100);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      sendCmd(VEC[v][0] != 0 ? 3'b111 : 3'b110);
      check("R3 mode cmd searches", locked, 0);
      dataLvl = ~dataLvl;
      tickOnce(0, t, r);
      check("R4 lock tx", t, 1);
      check("R4 locked", locked, 1);
      firstTx = 0;
      firstRx = 0;
      for (int k = 1; k <= 36; k++) begin
        if (k == VEC[v][1]) dataLvl = ~dataLvl;
        tickOnce(0, t, r);
        if (t && firstTx == 0) firstTx = k;
        if (r && firstRx == 0) firstRx = k;
      end
      check(reqName(VEC[v][4]), firstTx, VEC[v][2]);
      check(reqName(VEC[v][4]), firstRx, VEC[v][3]);
    end

    // R11: strobe is one clock wide
    sendCmd(3'b110);
    dataLvl = ~dataLvl;
    tickOnce(0, t, r);
    check("R11 strobe high", t, 1);
    @(negedge clk);
    check("R11 strobe one cycle", txClk, 0);

    // R2: source select
    sendCmd(3'b101);
    sendCmd(3'b110);
    dataLvl = ~dataLvl;
    tickOnce(0, t, r);
    check("R2 unselected source ignored", locked, 0);
    tickOnce(1, t, r);
    check("R2 pin source lock", t, 1);
    sendCmd(3'b100);

    // R2: no-op and unqualified code
    sendCmd(3'b000);
    check("R2 nop keeps lock", locked, 1);
    @(negedge clk);
    cmdCode = 3'b011;
    @(negedge clk);
    cmdCode = 3'b000;
    runIdle(32, cnt);
    check("R2 invalid cmd ignored", cnt, 2);

    // R2: disable freezes
    sendCmd(3'b011);
    runIdle(40, cnt);
    check("R2 disabled no strobes", cnt, 0);
    check("R2 disabled keeps state", locked, 1);
    sendCmd(3'b100);

    // R10: back to search
    sendCmd(3'b001);
    check("R10 locked drops", locked, 0);
    runIdle(40, cnt);
    check("R10 no strobes in search", cnt, 0);
    dataLvl = ~dataLvl;
    tickOnce(0, t, r);
    check("R10 relock", t, 1);

    // R9: missing clock in FM
    sendCmd(3'b111);
    sendCmd(3'b010);
    check("R9 cleared", missingClk, 0);
    dataLvl = ~dataLvl;
    tickOnce(0, t, r);
    runIdle(31, cnt);
    check("R9 not yet", missingClk, 0);
    tickOnce(0, t, r);
    check("R9 set at second boundary", missingClk, 1);
    runIdle(5, cnt);
    check("R9 sticky", missingClk, 1);
    sendCmd(3'b010);
    check("R9 clear cmd", missingClk, 0);

    // R9: never in NRZI
    sendCmd(3'b110);
    dataLvl = ~dataLvl;
    tickOnce(0, t, r);
    runIdle(70, cnt);
    check("R9 NRZI no flag", missingClk, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule